// File: doc/BRIEF.md
# Register-Window Bus Target

This block is the target side of a 32-bit parallel bus of the PCI kind. It answers I/O and memory cycles aimed at one small register window and turns each accepted data phase into a one-clock strobe on a local register-file port. During the address phase it compares all 32 address bits against a separate I/O base and memory base. It accepts the basic read and write commands, and it maps the cache-oriented memory commands onto the basic ones. Once it has claimed a cycle it inserts a programmable number of wait states before each data phase.

The first 32 bytes of the window hold locations where a read has side effects. The target therefore never fetches ahead. In that region it ends any burst with a disconnect that transfers one word. Above that region bursts run until the master stops or the window runs out.

The target has no tri-state pins. Each bus signal it can drive comes out as a separate value with an output enable. DEVSEL, TRDY and STOP share one enable, AD has its own enable and PAR has its own enable.

Top module: `pci_target_window`

## Requirements
- R1: A cycle is claimed only when its command is valid for the address space and all 32 address bits fall inside the window of that space. I/O commands are decoded against IO_BASE and memory commands against MEM_BASE, each window being WIN_BYTES long. A cycle that is not claimed leaves DEVSEL deasserted and the control enable low.
- R2: Command codes other than 0010, 0011, 0110, 0111, 1100, 1110 and 1111 are never claimed, even when the address matches. The code is active-high on C/BE[3:0] during the address phase.
- R3: Memory Read Multiple (1100) and Memory Read Line (1110) behave exactly like Memory Read (0110). Memory Write and Invalidate (1111) behaves exactly like Memory Write (0111).
- R4: DEVSEL goes low in the second clock after the clock that carried the address, which is medium decode timing. The control enable rises at the same time.
- R5: TRDY first goes low WAIT_STATES+1 clocks after DEVSEL goes low. Every later burst phase again waits WAIT_STATES+1 clocks after the previous transfer.
- R6: A write strobe fires only in a clock where both IRDY and TRDY are low. Its byte enables are the inverse of C/BE[3:0], so 8-, 16- and 32-bit writes touch only the selected bytes.
- R7: When a data phase at a byte offset below 32 starts while FRAME is still low, STOP is asserted together with TRDY. Exactly one word is transferred.
- R8: At offsets 32 and above, a burst transfers one word per data phase and advances the offset by 4 each time. The burst is disconnected at the last word of the window.
- R9: A read strobe fires exactly once per read data phase, in the clock before TRDY goes low, and never before the previous phase has transferred. No data is fetched ahead.
- R10: An address phase that directly follows another target's final data phase, with no idle clock between them, is recognised.
- R11: In the clock after each clock in which the target drove AD, PAR is enabled and equals the even parity of AD[31:0] and C/BE[3:0] from that clock.
- R12: After a transaction ends, DEVSEL, TRDY and STOP are driven high for one clock. After that the control enable is low.
- R13: The fast back-to-back capable flag output is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | FRAME from the master |
| irdyN | input | 1 | IRDY from the master |
| cbeN | input | 4 | Command during the address phase, byte enables (active low) during data phases |
| adIn | input | 32 | AD as seen on the bus |
| adOut | output | 32 | Read data driven on AD |
| adOe | output | 1 | Output enable for AD |
| parOut | output | 1 | Even parity driven on PAR |
| parOe | output | 1 | Output enable for PAR |
| devselN | output | 1 | DEVSEL value |
| trdyN | output | 1 | TRDY value |
| stopN | output | 1 | STOP value |
| ctlOe | output | 1 | Output enable for DEVSEL, TRDY and STOP |
| regOffset | output | log2(WIN_BYTES) | Word-aligned byte offset within the window |
| regRd | output | 1 | Read strobe for the register file |
| regWr | output | 1 | Write strobe for the register file |
| regByteEn | output | 4 | Active-high byte enables for a write |
| regWdata | output | 32 | Write data |
| regRdata | input | 32 | Read data returned by the register file |
| fastB2bCap | output | 1 | Fast back-to-back capable flag, constant 1 |

## Verification
The assertions check the following on every clock:
- DEVSEL falls two clocks after a claimed address phase.
- A rejected command leaves the bus untouched.
- TRDY is never low without DEVSEL.
- STOP appears beside TRDY only in the low region or on the last word of the window.
- Strobes fire only on real transfers, and a fetch is never repeated.

Only the bench's scenarios can show the following:
- The burst lengths actually transferred.
- That merged bytes land in the right register.
- That read data and parity match the bytes stored.
- That a cycle started straight after another target's data phase is still claimed.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_WAIT,
    ST_DATA,
    ST_HOLD,
    ST_TURN
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic incAddr;
    logic loadRdata;
  } dpStrobe_t;

  typedef struct packed {
    logic ok;
    logic isWrite;
    logic isIo;
  } cmdInfo_t;

  // command classification; cache-oriented memory commands fold onto the basic ones
  function automatic cmdInfo_t classifyCmd(input logic [3:0] c);
    cmdInfo_t r;
    case (c)
      4'b0010:                   r = '{1'b1, 1'b0, 1'b1};
      4'b0011:                   r = '{1'b1, 1'b1, 1'b1};
      4'b0110, 4'b1100, 4'b1110: r = '{1'b1, 1'b0, 1'b0};
      4'b0111, 4'b1111:          r = '{1'b1, 1'b1, 1'b0};
      default:                   r = '{1'b0, 1'b0, 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pci_tgt_dpath.sv
module pci_tgt_dpath
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] IO_BASE      = 32'h0000_C000,
  parameter logic [31:0] MEM_BASE     = 32'hFEB0_0000,
  parameter int          WIN_BYTES    = 128,
  parameter int          LEGACY_BYTES = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [31:0]                  adIn,
  input  logic [3:0]                   cbeN,
  input  logic                         adOe,
  input  dpStrobe_t                    strobe,
  input  logic [31:0]                  regRdata,
  output logic                         ioHit,
  output logic                         memHit,
  output logic                         edgeRegion,
  output logic [$clog2(WIN_BYTES)-1:0] regOffset,
  output logic [31:0]                  adOut,
  output logic                         parOut,
  output logic                         parOe
);

  localparam int          WIN_AW  = $clog2(WIN_BYTES);
  localparam logic [31:0] HI_MASK = ~(32'(WIN_BYTES) - 32'd1);

  logic [WIN_AW-3:0] offQ;

  // full 32-bit window compare
  assign ioHit  = (adIn & HI_MASK) == (IO_BASE & HI_MASK);
  assign memHit = (adIn & HI_MASK) == (MEM_BASE & HI_MASK);

  assign regOffset  = {offQ, 2'b00};
  assign edgeRegion = (regOffset < WIN_AW'(LEGACY_BYTES)) || (&offQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ   <= '0;
      adOut  <= '0;
      parOut <= 1'b0;
      parOe  <= 1'b0;
    end else begin
      if (strobe.latchAddr)
        offQ <= adIn[WIN_AW-1:2];
      else if (strobe.incAddr)
        offQ <= offQ + (WIN_AW-2)'(1);
      if (strobe.loadRdata)
        adOut <= regRdata;
      parOut <= ^{adOut, cbeN};
      parOe  <= adOe;
    end
  end

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
#(
  parameter int WAIT_STATES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic [3:0] cbeN,
  input  logic       ioHit,
  input  logic       memHit,
  input  logic       edgeRegion,
  output dpStrobe_t  strobe,
  output logic       devselN,
  output logic       trdyN,
  output logic       stopN,
  output logic       ctlOe,
  output logic       adOe,
  output logic       regRd,
  output logic       regWr
);

  localparam int CNT_W = $clog2(WAIT_STATES + 2);

  tgtState_t  state;
  logic [CNT_W-1:0] cnt;
  logic       frameQ;
  logic       isWriteQ;
  cmdInfo_t   info;
  logic       addrPhase, canStart, claim, xfer;

  assign info      = classifyCmd(cbeN);
  // new address phase: FRAME low now, high at the previous edge (no idle needed)
  assign addrPhase = !frameN && frameQ;
  assign canStart  = (state == ST_IDLE) || (state == ST_TURN);
  assign claim     = info.ok && (info.isIo ? ioHit : memHit);
  assign xfer      = (state == ST_DATA) && !irdyN;

  assign strobe.latchAddr = canStart && addrPhase;
  assign strobe.incAddr   = xfer && !frameN && stopN;
  assign strobe.loadRdata = (state == ST_WAIT) && (cnt == '0) && !isWriteQ;
  assign regRd = strobe.loadRdata;
  assign regWr = xfer && isWriteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      frameQ   <= 1'b1;
      isWriteQ <= 1'b0;
      devselN  <= 1'b1;
      trdyN    <= 1'b1;
      stopN    <= 1'b1;
      ctlOe    <= 1'b0;
      adOe     <= 1'b0;
    end else begin
      frameQ <= frameN;
      case (state)
        ST_IDLE, ST_TURN: begin
          devselN <= 1'b1;
          trdyN   <= 1'b1;
          stopN   <= 1'b1;
          ctlOe   <= 1'b0;
          adOe    <= 1'b0;
          if (canStart && addrPhase && claim) begin
            state    <= ST_DECODE;
            isWriteQ <= info.isWrite;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DECODE: begin
          devselN <= 1'b0;
          ctlOe   <= 1'b1;
          adOe    <= !isWriteQ;
          cnt     <= CNT_W'(WAIT_STATES);
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            trdyN <= 1'b0;
            stopN <= !(edgeRegion && !frameN);
            state <= ST_DATA;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (!irdyN) begin
            trdyN <= 1'b1;
            if (frameN) begin
              devselN <= 1'b1;
              stopN   <= 1'b1;
              adOe    <= 1'b0;
              state   <= ST_TURN;
            end else if (!stopN) begin
              state <= ST_HOLD;
            end else begin
              cnt   <= CNT_W'(WAIT_STATES);
              state <= ST_WAIT;
            end
          end
        end
        ST_HOLD: begin
          if (frameN) begin
            devselN <= 1'b1;
            stopN   <= 1'b1;
            adOe    <= 1'b0;
            state   <= ST_TURN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: medium decode timing
  a_r4_devsel_medium: assert property (@(posedge clk) disable iff (!rstN)
    (canStart && addrPhase && claim) |-> ##2 (!devselN && ctlOe));

  // R2: rejected command leaves the bus alone
  a_r2_no_claim_bad_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (canStart && addrPhase && !info.ok) |=> (devselN && !ctlOe));

  // R5: TRDY only inside a claimed cycle
  a_r5_trdy_needs_devsel: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> (!devselN && ctlOe));

  // R7: disconnect only where bursts are refused
  a_r7_stop_only_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !stopN) |-> edgeRegion);

  // R8: burst continues without STOP above the low region
  a_r8_burst_no_stop: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && stopN && !frameN) |-> !edgeRegion);

  // R9: one fetch per data phase, never while TRDY is pending
  a_r9_single_fetch: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> (trdyN ##1 !regRd));

  // R6: writes only on a completed transfer
  a_r6_write_on_transfer: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> (!irdyN && !trdyN && !devselN));

endmodule

// File: rtl/pci_target_window.sv
module pci_target_window
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] IO_BASE      = 32'h0000_C000,
  parameter logic [31:0] MEM_BASE     = 32'hFEB0_0000,
  parameter int          WIN_BYTES    = 128,
  parameter int          LEGACY_BYTES = 32,
  parameter int          WAIT_STATES  = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frameN,
  input  logic                         irdyN,
  input  logic [3:0]                   cbeN,
  input  logic [31:0]                  adIn,
  output logic [31:0]                  adOut,
  output logic                         adOe,
  output logic                         parOut,
  output logic                         parOe,
  output logic                         devselN,
  output logic                         trdyN,
  output logic                         stopN,
  output logic                         ctlOe,
  output logic [$clog2(WIN_BYTES)-1:0] regOffset,
  output logic                         regRd,
  output logic                         regWr,
  output logic [3:0]                   regByteEn,
  output logic [31:0]                  regWdata,
  input  logic [31:0]                  regRdata,
  output logic                         fastB2bCap
);

  dpStrobe_t strobe;
  logic      ioHit, memHit, edgeRegion;

  assign regByteEn  = ~cbeN;
  assign regWdata   = adIn;
  assign fastB2bCap = 1'b1;

  pci_tgt_ctrl #(
    .WAIT_STATES (WAIT_STATES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameN     (frameN),
    .irdyN      (irdyN),
    .cbeN       (cbeN),
    .ioHit      (ioHit),
    .memHit     (memHit),
    .edgeRegion (edgeRegion),
    .strobe     (strobe),
    .devselN    (devselN),
    .trdyN      (trdyN),
    .stopN      (stopN),
    .ctlOe      (ctlOe),
    .adOe       (adOe),
    .regRd      (regRd),
    .regWr      (regWr)
  );

  pci_tgt_dpath #(
    .IO_BASE      (IO_BASE),
    .MEM_BASE     (MEM_BASE),
    .WIN_BYTES    (WIN_BYTES),
    .LEGACY_BYTES (LEGACY_BYTES)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .adIn       (adIn),
    .cbeN       (cbeN),
    .adOe       (adOe),
    .strobe     (strobe),
    .regRdata   (regRdata),
    .ioHit      (ioHit),
    .memHit     (memHit),
    .edgeRegion (edgeRegion),
    .regOffset  (regOffset),
    .adOut      (adOut),
    .parOut     (parOut),
    .parOe      (parOe)
  );

endmodule

// File: tb/sim_pci_target_window.sv
module sim_pci_target_window;

  localparam logic [31:0] IOB   = 32'h0000_C000;
  localparam logic [31:0] MEMB  = 32'hFEB0_0000;
  localparam int          WAITS = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1, irdyN = 1'b1;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] adIn = '0;
  logic [31:0] adOut, regWdata, regRdata;
  logic        adOe, parOut, parOe, devselN, trdyN, stopN, ctlOe;
  logic [6:0]  regOffset;
  logic        regRd, regWr, fastB2bCap;
  logic [3:0]  regByteEn;

  logic [31:0] rf [32];
  logic [31:0] expMem [32];
  int          rdCount = 0;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  pci_target_window #(
    .IO_BASE(IOB), .MEM_BASE(MEMB), .WIN_BYTES(128), .LEGACY_BYTES(32), .WAIT_STATES(WAITS)
  ) u0 (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .parOut(parOut), .parOe(parOe), .devselN(devselN),
    .trdyN(trdyN), .stopN(stopN), .ctlOe(ctlOe), .regOffset(regOffset), .regRd(regRd),
    .regWr(regWr), .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(regRdata),
    .fastB2bCap(fastB2bCap)
  );

  // local register file served by the bench
  always_comb regRdata = rf[regOffset[6:2]];

  always @(posedge clk) begin
    if (regRd) rdCount <= rdCount + 1;
    if (regWr)
      for (int b = 0; b < 4; b++)
        if (regByteEn[b]) rf[regOffset[6:2]][8*b +: 8] <= regWdata[8*b +: 8];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic int expectXfers(input bit claimed, input int off, input int nPh);
    int room;
    if (!claimed) return 0;
    if (off < 32) return 1;
    room = (128 - off) / 4;
    return (nPh < room) ? nPh : room;
  endfunction

  function automatic bit expectClaim(input logic [31:0] addr, input logic [3:0] cmd);
    bit ok, io;
    ok = (cmd == 4'b0010) || (cmd == 4'b0011) || (cmd == 4'b0110) || (cmd == 4'b0111) ||
         (cmd == 4'b1100) || (cmd == 4'b1110) || (cmd == 4'b1111);
    io = (cmd == 4'b0010) || (cmd == 4'b0011);
    if (!ok) return 0;
    return io ? ((addr & 32'hFFFF_FF80) == IOB) : ((addr & 32'hFFFF_FF80) == MEMB);
  endfunction

  task automatic memCompare(input string tag);
    int bad = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== expMem[i]) bad++;
    chk(bad == 0, "R6", {tag, " register image"}, bad, 0);
  endtask

  // one master transaction, entered and left at a negedge
  task automatic runTxn(input logic [31:0] addr, input logic [3:0] cmd,
                        input int nPh, input logic [3:0] be, input string tag);
    bit   claimed, isWr, done, prevXfer, stopSeen, pendPar;
    logic expPar;
    int   firstTrdy, xf, word, rd0, expX;
    claimed = expectClaim(addr, cmd);
    isWr    = cmd[0];
    word    = int'(addr[6:2]);
    expX    = expectXfers(claimed, word * 4, nPh);
    rd0     = rdCount;
    done = 0; prevXfer = 0; stopSeen = 0; pendPar = 0; expPar = 0;
    firstTrdy = -1; xf = 0;
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd;
    @(negedge clk);
    chk(devselN === 1'b1, "R4", {tag, " DEVSEL early"}, devselN, 1);
    cbeN = ~be; adIn = $urandom; irdyN = 1'b0; frameN = (nPh == 1);
    if (!claimed) begin
      for (int c = 2; c <= 5; c++) begin
        @(negedge clk);
        chk(devselN && !ctlOe, "R1", {tag, " unclaimed bus quiet"}, {devselN, ctlOe}, 2'b10);
      end
      frameN = 1'b1;
      @(negedge clk);
      irdyN = 1'b1;
      @(negedge clk);
      memCompare(tag);
      return;
    end
    for (int cyc = 2; cyc < 60 && !done; cyc++) begin
      @(negedge clk);
      if (pendPar) begin
        chk(parOe && parOut === expPar, "R11", {tag, " parity"}, {parOe, parOut}, {1'b1, expPar});
        pendPar = 0;
      end
      if (cyc == 2)
        chk(!devselN && ctlOe, "R4", {tag, " DEVSEL medium"}, {devselN, ctlOe}, 2'b01);
      if (frameN && ctlOe && devselN) begin
        chk(trdyN && stopN, "R12", {tag, " turnaround high"}, {trdyN, stopN}, 2'b11);
        irdyN = 1'b1;
        @(negedge clk);
        chk(!ctlOe, "R12", {tag, " released"}, ctlOe, 0);
        done = 1;
      end else begin
        if (prevXfer) begin
          if (stopSeen) frameN = 1'b1;
          else if (xf < nPh) begin
            adIn = $urandom; cbeN = ~be;
            if (xf == nPh - 1) frameN = 1'b1;
          end
        end else if (stopSeen && !frameN) begin
          frameN = 1'b1;
        end
        if (!trdyN && firstTrdy < 0) firstTrdy = cyc;
        if (!stopN) stopSeen = 1;
        prevXfer = !trdyN && !irdyN;
        if (prevXfer) begin
          if (isWr) begin
            for (int b = 0; b < 4; b++)
              if (be[b]) expMem[word][8*b +: 8] = adIn[8*b +: 8];
          end else begin
            chk(adOut === expMem[word], "R9", {tag, " read data"}, adOut, expMem[word]);
            expPar = ^{adOut, cbeN};
            pendPar = 1;
          end
          xf++; word++;
        end
      end
    end
    chk(done, "R12", {tag, " transaction ended"}, done, 1);
    chk(firstTrdy == 3 + WAITS, "R5", {tag, " first TRDY clock"}, firstTrdy, 3 + WAITS);
    chk(xf == expX, (word * 4 - xf * 4 < 32) ? "R7" : "R8", {tag, " words moved"}, xf, expX);
    chk(rdCount - rd0 == (isWr ? 0 : xf), "R9", {tag, " fetch count"}, rdCount - rd0, isWr ? 0 : xf);
    if (isWr) memCompare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      rf[i] = $urandom;
      expMem[i] = rf[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(devselN && trdyN && stopN && !ctlOe && !adOe && !parOe && !regRd && !regWr,
        "R12", "reset idle", {devselN, trdyN, stopN, ctlOe}, 4'b1110);
    chk(fastB2bCap === 1'b1, "R13", "fast b2b flag", fastB2bCap, 1);

    runTxn(IOB + 32'h40, 4'b0011, 1, 4'hF, "R1 io write");
    runTxn(IOB + 32'h40, 4'b0010, 1, 4'hF, "R1 io read");
    runTxn(IOB + 32'h44, 4'b0011, 1, 4'b0001, "R6 byte write");
    runTxn(IOB + 32'h48, 4'b0011, 1, 4'b1100, "R6 half write");
    runTxn(MEMB + 32'h50, 4'b1111, 3, 4'hF, "R3 invalidate write");
    runTxn(MEMB + 32'h50, 4'b1110, 3, 4'hF, "R3 read line");
    runTxn(MEMB + 32'h44, 4'b1100, 2, 4'hF, "R3 read multiple");
    runTxn(IOB + 32'h08, 4'b0011, 3, 4'hF, "R7 low burst write");
    runTxn(MEMB + 32'h14, 4'b0110, 4, 4'hF, "R7 low burst read");
    runTxn(MEMB + 32'h78, 4'b0111, 4, 4'hF, "R8 window end");
    runTxn(MEMB + 32'h20, 4'b0110, 4, 4'hF, "R8 burst at 32");
    runTxn(IOB + 32'h40, 4'b1010, 1, 4'hF, "R2 bad cmd");
    runTxn(MEMB + 32'h40, 4'b0010, 1, 4'hF, "R1 io to mem window");
    runTxn(IOB | 32'h8000_0000, 4'b0011, 1, 4'hF, "R1 high bit");

    // R10: another target's transaction, then ours with no idle clock
    frameN = 1'b0; irdyN = 1'b1; adIn = 32'h1234_5600; cbeN = 4'b0110;
    @(negedge clk);
    frameN = 1'b1; irdyN = 1'b0; cbeN = 4'h0;
    @(negedge clk);
    runTxn(IOB + 32'h60, 4'b0011, 1, 4'hF, "R10 back to back");

    for (int n = 0; n < 80; n++) begin
      logic [3:0]  cmds [8];
      logic [3:0]  cmd;
      logic [31:0] base;
      cmds = '{4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111, 4'b1011};
      cmd  = cmds[$urandom % 8];
      base = ((cmd == 4'b0010) || (cmd == 4'b0011)) ? IOB : MEMB;
      if ($urandom % 10 == 0) base = base ^ 32'h0001_0000;
      runTxn(base + {25'd0, 5'($urandom % 32), 2'b00}, cmd, 1 + ($urandom % 4),
             4'(1 + ($urandom % 15)), "random R1 R3 R8");
      if ($urandom % 2) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule